// File: doc/BRIEF.md
# Fault Qualification and Latching Supervisor

This block sits between the analog protection comparators of a boost-based LED driver and its power state machine. It takes eleven raw fault levels: input overvoltage, input undervoltage, input overcurrent, boost overcurrent, boost overvoltage, charge pump low, thermal shutdown, thermistor high level, thermistor low level, missing thermistor and supply undervoltage. Each level passes through its own deglitch filter, sized in microseconds and scaled by a clock-ticks-per-microsecond parameter. It is accepted only while the enable window for its power-up phase is open.

Qualified faults set sticky status flags. The flags drive an active-low fault output and raise a recovery request to the sequencer. Supply undervoltage is handled apart from the rest: it sets no flag, leaves the fault output alone, and raises a standby request only while it lasts. Flags clear on a clear-faults pulse, on a rising edge of the serial chip-select line, or when the block is disabled. A thermistor level flag clears only while its raw level is low. Three mask inputs limit what the overvoltage, boost overcurrent and input undervoltage faults can cause.

Top module: `fault_supervisor`

## Requirements
- R1: A raw input qualifies only after it has been high and its window open at LIMIT consecutive rising clock edges. LIMIT is filter_us × TICKS_PER_US. The filter times are: long (boost overcurrent, index 3); medium (indices 0, 1, 2, 4, 6, 9); fast (indices 5, 7, 8); supply (index 10). Any edge with the input low restarts the count, and the qualification drops at the first edge where the input is low.
- R2: phase_i encodes 0 idle, 1 soft start, 2 boost running, 3 normal run. Indices 0, 1, 2 and 6 are enabled for phase ≥ 1. Indices 3 and 5 are enabled for phase ≥ 2. Indices 4, 7, 8 and 9 are enabled only in phase 3. Index 10 is always enabled. All windows except index 10 also need en_i high. A closed window restarts the filter.
- R3: A qualified fault with index 0 to 9 sets status_o[index] one clock after it qualifies. The bit stays set after the raw input goes away, until a clear occurs.
- R4: recover_req_o is high while any of indices 0, 1, 2, 3, 5 or 6 is qualified and not blocked. mask_ovp_rec_i blocks only the recovery for index 0. mask_bocp_rec_i blocks only the recovery for index 3. Neither mask affects the status bit or fault_n_o.
- R5: While mask_uv_all_i is high, input undervoltage (index 1) raises no recovery request and does not set its status bit, so it cannot pull fault_n_o low.
- R6: fault_n_o is low exactly when any of status_o[8:0] is set. Missing thermistor (bit 9) never pulls it low.
- R7: standby_req_o follows qualified supply undervoltage (index 10) and drops at the first edge after the raw input falls. It sets no status bit.
- R8: A high clear_i at a clock edge clears the status bits at that edge. While en_i is low, all status bits are held at zero.
- R9: A low-to-high change on cs_n_i passes through a two-flop synchronizer and clears the status bits at the third rising clock edge after the change.
- R10: While ntc_comp_en_i is low, indices 7, 8 and 9 never qualify.
- R11: A clear, whether from clear_i or from cs_n_i, leaves status bit 7 or 8 set while its raw input is high at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low clears flags and closes the windows |
| phase_i | input | 2 | Power-up phase: 0 idle, 1 soft start, 2 boost, 3 run |
| raw_i | input | 11 | Raw comparator levels, one bit per fault index |
| ntc_comp_en_i | input | 1 | External temperature compensation enable |
| mask_ovp_rec_i | input | 1 | Blocks recovery for input overvoltage |
| mask_bocp_rec_i | input | 1 | Blocks recovery for boost overcurrent |
| mask_uv_all_i | input | 1 | Blocks recovery, flag and pin for input undervoltage |
| clear_i | input | 1 | Clear-faults pulse |
| cs_n_i | input | 1 | Asynchronous serial chip-select; a rising edge clears flags |
| status_o | output | 10 | Sticky fault flags, indices 0 to 9 |
| fault_n_o | output | 1 | Active-low fault indication |
| recover_req_o | output | 1 | Request to enter fault recovery |
| standby_req_o | output | 1 | Request to enter standby |

## Verification
A filter counter that is off by one cycle, or one that fails to restart, shows up as a recovery or standby request that rises one edge early or late. The status flag then moves one cycle behind it. A wrong enable window or mask shows up in the same cycle as a request or flag that should not be there. A clear path that ignores its guard, or a synchronizer with the wrong depth, shows up as a flag that drops at the wrong edge. The bench's model predicts every output on every cycle, so each of these faults is reported in the cycle where it first appears.

// File: rtl/fault_sup_pkg.sv
package fault_sup_pkg;
  localparam int unsigned NUM_FAULTS = 11;
  localparam int unsigned NUM_FLAGS  = 10;

  localparam int unsigned F_VIN_OV   = 0;
  localparam int unsigned F_VIN_UV   = 1;
  localparam int unsigned F_IN_OC    = 2;
  localparam int unsigned F_BST_OC   = 3;
  localparam int unsigned F_BST_OV   = 4;
  localparam int unsigned F_CP_LOW   = 5;
  localparam int unsigned F_TSD      = 6;
  localparam int unsigned F_NTC_HI   = 7;
  localparam int unsigned F_NTC_LO   = 8;
  localparam int unsigned F_NTC_MISS = 9;
  localparam int unsigned F_VDD_UV   = 10;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SOFT  = 2'd1,
    PH_BOOST = 2'd2,
    PH_RUN   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {WIN_SOFT, WIN_BOOST, WIN_RUN, WIN_ALWAYS} win_e;
  typedef enum logic [1:0] {TM_LONG, TM_MID, TM_FAST, TM_SUPPLY} tmclass_e;

  // faults that request recovery: 0,1,2,3,5,6
  localparam logic [NUM_FAULTS-1:0] REC_SET = 11'h06F;
  // flags wired to the pin: 0..8
  localparam logic [NUM_FAULTS-1:0] PIN_SET = 11'h1FF;
  // thermistor levels: clear held off while raw is high
  localparam logic [NUM_FAULTS-1:0] NTC_LVL = 11'h180;
  // all thermistor related faults
  localparam logic [NUM_FAULTS-1:0] NTC_ANY = 11'h380;

  function automatic win_e win_of(int unsigned idx);
    case (idx)
      F_VIN_OV, F_VIN_UV, F_IN_OC, F_TSD: return WIN_SOFT;
      F_BST_OC, F_CP_LOW:                 return WIN_BOOST;
      F_BST_OV, F_NTC_HI, F_NTC_LO, F_NTC_MISS: return WIN_RUN;
      default:                            return WIN_ALWAYS;
    endcase
  endfunction

  function automatic tmclass_e tm_of(int unsigned idx);
    case (idx)
      F_BST_OC:                     return TM_LONG;
      F_CP_LOW, F_NTC_HI, F_NTC_LO: return TM_FAST;
      F_VDD_UV:                     return TM_SUPPLY;
      default:                      return TM_MID;
    endcase
  endfunction

  function automatic logic window_open(win_e w, logic [1:0] ph, logic en);
    case (w)
      WIN_SOFT:  return en && (ph != PH_IDLE);
      WIN_BOOST: return en && (ph == PH_BOOST || ph == PH_RUN);
      WIN_RUN:   return en && (ph == PH_RUN);
      default:   return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/fault_filter.sv
module fault_filter #(
  parameter int unsigned LIMIT = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic raw_i,
  output logic qual_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             qual_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      qual_q <= 1'b0;
    end else if (!(arm_i && raw_i)) begin
      cnt_q  <= '0;
      qual_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      qual_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign qual_o = qual_q;
endmodule

// File: rtl/cs_rise_detect.sv
module cs_rise_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  // idle-high reset so release of reset is not seen as an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= cs_n_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q && !s3_q;
endmodule

// File: rtl/fault_latch.sv
module fault_latch
  import fault_sup_pkg::*;
#(
  parameter int unsigned NF = NUM_FLAGS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NF-1:0] qual_i,
  input  logic [NF-1:0] raw_i,
  input  logic          clr_i,
  input  logic          mask_uv_i,
  output logic [NF-1:0] status_o
);
  logic [NF-1:0] set_vec, hold_vec, clr_vec, status_q;

  always_comb begin
    set_vec           = qual_i;
    set_vec[F_VIN_UV] = qual_i[F_VIN_UV] && !mask_uv_i;
    hold_vec          = NTC_LVL[NF-1:0] & raw_i;
    clr_vec           = {NF{clr_i}} & ~hold_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    status_q <= '0;
    else if (!en_i) status_q <= '0;
    else            status_q <= (status_q & ~clr_vec) | set_vec;
  end

  assign status_o = status_q;
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fault_sup_pkg::*;
#(
  parameter int unsigned TICKS_PER_US = 50,
  parameter int unsigned T_LONG_US    = 110000,
  parameter int unsigned T_MID_US     = 100,
  parameter int unsigned T_FAST_US    = 10,
  parameter int unsigned T_SUPPLY_US  = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [1:0]           phase_i,
  input  logic [NUM_FAULTS-1:0] raw_i,
  input  logic                 ntc_comp_en_i,
  input  logic                 mask_ovp_rec_i,
  input  logic                 mask_bocp_rec_i,
  input  logic                 mask_uv_all_i,
  input  logic                 clear_i,
  input  logic                 cs_n_i,
  output logic [NUM_FLAGS-1:0] status_o,
  output logic                 fault_n_o,
  output logic                 recover_req_o,
  output logic                 standby_req_o
);
  localparam int unsigned LIM_MAX = T_LONG_US * TICKS_PER_US;
  localparam int unsigned CNT_W   = $clog2(LIM_MAX + 1);

  logic [NUM_FAULTS-1:0] arm, qual, rec_block;
  logic                  cs_clr;

  for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_chan
    localparam tmclass_e    TC  = tm_of(g);
    localparam int unsigned LIM = (TC == TM_LONG) ? T_LONG_US * TICKS_PER_US :
                                  (TC == TM_MID)  ? T_MID_US * TICKS_PER_US :
                                  (TC == TM_FAST) ? T_FAST_US * TICKS_PER_US :
                                                    T_SUPPLY_US * TICKS_PER_US;
    assign arm[g] = window_open(win_of(g), phase_i, en_i) &&
                    (!NTC_ANY[g] || ntc_comp_en_i);

    fault_filter #(.LIMIT(LIM), .CNT_W(CNT_W)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .arm_i (arm[g]),
      .raw_i (raw_i[g]),
      .qual_o(qual[g])
    );
  end

  cs_rise_detect u_cs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_n_i(cs_n_i),
    .rise_o(cs_clr)
  );

  fault_latch #(.NF(NUM_FLAGS)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .qual_i   (qual[NUM_FLAGS-1:0]),
    .raw_i    (raw_i[NUM_FLAGS-1:0]),
    .clr_i    (clear_i || cs_clr),
    .mask_uv_i(mask_uv_all_i),
    .status_o (status_o)
  );

  always_comb begin
    rec_block           = '0;
    rec_block[F_VIN_OV] = mask_ovp_rec_i;
    rec_block[F_BST_OC] = mask_bocp_rec_i;
    rec_block[F_VIN_UV] = mask_uv_all_i;
  end

  assign recover_req_o = |(qual & REC_SET & ~rec_block);
  assign fault_n_o     = ~|(status_o & PIN_SET[NUM_FLAGS-1:0]);
  assign standby_req_o = qual[F_VDD_UV];
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk
  import fault_sup_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  en_i,
  input logic [NUM_FAULTS-1:0] raw_i,
  input logic                  ntc_comp_en_i,
  input logic                  mask_uv_all_i,
  input logic                  clear_i,
  input logic                  cs_clr_i,
  input logic [NUM_FLAGS-1:0]  status_o,
  input logic                  recover_req_o,
  input logic                  standby_req_o
);
  AST_QUAL_NEEDS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_req_o |-> (|($past(raw_i) & REC_SET)));  // R1

  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !$past(clear_i) && !$past(cs_clr_i)) |->
      ((status_o & $past(status_o)) == $past(status_o)));  // R3

  AST_UV_MASK_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mask_uv_all_i) && !$past(status_o[F_VIN_UV])) |-> !status_o[F_VIN_UV]);  // R5

  AST_STANDBY_NEEDS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_req_o |-> $past(raw_i[F_VDD_UV]));  // R7

  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (status_o == '0));  // R8

  AST_NTC_OFF_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(ntc_comp_en_i, 2) && ($past(status_o[9:7]) == 3'b000)) |->
      (status_o[9:7] == 3'b000));  // R10
endmodule

bind fault_supervisor fault_supervisor_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .raw_i        (raw_i),
  .ntc_comp_en_i(ntc_comp_en_i),
  .mask_uv_all_i(mask_uv_all_i),
  .clear_i      (clear_i),
  .cs_clr_i     (cs_clr),
  .status_o     (status_o),
  .recover_req_o(recover_req_o),
  .standby_req_o(standby_req_o)
);

// File: tb/fault_supervisor_tb_top.sv
module fault_supervisor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  phase = 2'd0;
  logic [10:0] raw = '0;
  logic        ntc = 1'b0;
  logic        m_ovp = 1'b0, m_bocp = 1'b0, m_uv = 1'b0;
  logic        clr = 1'b0;
  logic        cs_n = 1'b1;
  logic [9:0]  status;
  logic        fault_n, rec, stb;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  fault_supervisor #(
    .TICKS_PER_US(2), .T_LONG_US(20), .T_MID_US(5), .T_FAST_US(2), .T_SUPPLY_US(1)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .phase_i(phase), .raw_i(raw),
    .ntc_comp_en_i(ntc), .mask_ovp_rec_i(m_ovp), .mask_bocp_rec_i(m_bocp),
    .mask_uv_all_i(m_uv), .clear_i(clr), .cs_n_i(cs_n), .status_o(status),
    .fault_n_o(fault_n), .recover_req_o(rec), .standby_req_o(stb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int run [11];
  bit q [11];
  bit st [10];
  bit csq [$];

  function automatic int lim(int i);
    case (i)
      3: return 40;
      5, 7, 8: return 4;
      10: return 2;
      default: return 10;
    endcase
  endfunction

  function automatic bit mwin(int i);
    case (i)
      0, 1, 2, 6: return en && phase >= 2'd1;
      3, 5: return en && phase >= 2'd2;
      4: return en && phase == 2'd3;
      7, 8, 9: return en && phase == 2'd3 && ntc;
      default: return 1'b1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (run[i]) begin run[i] = 0; q[i] = 0; end
      foreach (st[i]) st[i] = 0;
      csq = {1'b1, 1'b1, 1'b1};
    end else begin
      bit qold [11];
      bit any_clr;
      qold = q;
      any_clr = clr || (csq[1] && !csq[0]);
      void'(csq.pop_front());
      csq.push_back(cs_n);
      for (int i = 0; i < 11; i++) begin
        if (raw[i] && mwin(i)) begin
          if (run[i] < lim(i)) run[i]++;
        end else run[i] = 0;
        q[i] = run[i] >= lim(i);
      end
      for (int i = 0; i < 10; i++) begin
        if (!en) st[i] = 0;
        else begin
          bit keep, setb;
          keep = st[i] && !(any_clr && !((i == 7 || i == 8) && raw[i]));
          setb = qold[i] && !(i == 1 && m_uv);
          st[i] = keep || setb;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [9:0] es;
      bit efn, erec;
      for (int i = 0; i < 10; i++) es[i] = st[i];
      efn = 1'b1;
      for (int i = 0; i < 9; i++) if (st[i]) efn = 1'b0;
      erec = (q[0] && !m_ovp) || (q[1] && !m_uv) || q[2] || (q[3] && !m_bocp) || q[5] || q[6];
      chk(status == es, "R3 model status", int'(status), int'(es));
      chk(fault_n == efn, "R6 model fault_n", int'(fault_n), int'(efn));
      chk(rec == erec, "R4 model recover", int'(rec), int'(erec));
      chk(stb == q[10], "R7 model standby", int'(stb), int'(q[10]));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #4;
  endtask

  task automatic pulse_clear();
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
  endtask

  initial begin
    tick(3);
    chk(status == 10'h0 && fault_n && !rec && !stb, "reset state", int'(status), 0);
    rst_n = 1'b1;
    tick(1);
    en = 1'b1;
    phase = 2'd1;
    // R1 exact qualification time
    raw[0] = 1'b1;
    tick(9);
    chk(rec == 1'b0, "R1 not yet qualified", rec, 0);
    tick(1);
    chk(rec == 1'b1, "R1 qualified at limit", rec, 1);
    tick(1);
    chk(status[0] == 1'b1, "R3 flag set", status[0], 1);
    raw[0] = 1'b0;
    tick(3);
    chk(status[0] == 1'b1 && !fault_n && !rec, "R3 flag sticky", int'(status), 1);
    // R1 glitch restarts count
    raw[2] = 1'b1; tick(5);
    raw[2] = 1'b0; tick(1);
    raw[2] = 1'b1; tick(9);
    chk(status[2] == 1'b0, "R1 glitch restart", status[2], 0);
    raw[2] = 1'b0;
    // R2 boost window
    raw[3] = 1'b1;
    tick(50);
    chk(status[3] == 1'b0 && !rec, "R2 boost fault closed in soft start", int'(status[3]), 0);
    phase = 2'd2;
    tick(40);
    chk(rec == 1'b1, "R2 boost fault qualifies in boost phase", rec, 1);
    tick(1);
    chk(status[3] == 1'b1, "R2 boost flag", status[3], 1);
    raw[3] = 1'b0;
    tick(1);
    pulse_clear();
    chk(status == 10'h0 && fault_n, "R8 clear pulse", int'(status), 0);
    // R4 ovp mask
    m_ovp = 1'b1;
    raw[0] = 1'b1;
    tick(12);
    chk(rec == 1'b0, "R4 ovp mask blocks recovery", rec, 0);
    chk(status[0] == 1'b1 && !fault_n, "R4 ovp mask keeps flag and pin", int'(status[0]), 1);
    raw[0] = 1'b0; m_ovp = 1'b0;
    tick(1);
    pulse_clear();
    // R5 undervoltage full mask
    m_uv = 1'b1;
    raw[1] = 1'b1;
    tick(12);
    chk(status[1] == 1'b0 && fault_n && !rec, "R5 uv mask blocks all", int'(status), 0);
    raw[1] = 1'b0;
    tick(1);
    m_uv = 1'b0;
    // R10 thermistor gated by compensation enable
    phase = 2'd3;
    raw[7] = 1'b1;
    tick(10);
    chk(status[7] == 1'b0, "R10 ntc disabled", status[7], 0);
    ntc = 1'b1;
    tick(6);
    chk(status[7] == 1'b1 && !fault_n, "R10 ntc enabled sets flag", status[7], 1);
    // R11 clear held while raw high
    pulse_clear();
    chk(status[7] == 1'b1, "R11 clear held while raw high", status[7], 1);
    raw[7] = 1'b0;
    tick(1);
    pulse_clear();
    chk(status[7] == 1'b0, "R11 clear after raw low", status[7], 0);
    // R6 missing thermistor flag does not reach pin
    raw[9] = 1'b1;
    tick(12);
    chk(status[9] == 1'b1 && fault_n, "R6 missing ntc not on pin", int'(fault_n), 1);
    raw[9] = 1'b0;
    tick(1);
    pulse_clear();
    // R7 supply undervoltage
    raw[10] = 1'b1;
    tick(2);
    chk(stb == 1'b1 && status == 10'h0 && fault_n, "R7 standby no flag", stb, 1);
    raw[10] = 1'b0;
    tick(1);
    chk(stb == 1'b0, "R7 standby released", stb, 0);
    // R9 chip-select toggle clear
    raw[6] = 1'b1;
    tick(12);
    raw[6] = 1'b0;
    tick(2);
    cs_n = 1'b0;
    tick(3);
    cs_n = 1'b1;
    tick(2);
    chk(status[6] == 1'b1, "R9 not cleared before third edge", status[6], 1);
    tick(1);
    chk(status[6] == 1'b0, "R9 cleared at third edge", status[6], 0);
    // R8 enable low clears, R2 filter restarts
    raw[5] = 1'b1;
    tick(6);
    chk(status[5] == 1'b1, "R3 charge pump flag", status[5], 1);
    en = 1'b0;
    tick(1);
    chk(status == 10'h0 && !rec, "R8 disable clears", int'(status), 0);
    en = 1'b1;
    tick(3);
    chk(rec == 1'b0, "R2 filter restarted after window closed", rec, 0);
    tick(1);
    chk(rec == 1'b1, "R2 requalified", rec, 1);
    raw[5] = 1'b0;
    tick(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule